// File: doc/BRIEF.md
# Coalescing Character Output Buffer

This block gathers characters that a processor emits one at a time and holds them in a small local store. It does not ask the host to print each byte. It raises one flush request that carries the number of bytes held. The host then reads the bytes out through a read port and acknowledges. After the acknowledge the store is empty again. This keeps the number of host access windows small.

A flush starts in one of three cases:
- a newline (0x0A) is written; the newline is stored first;
- the store reaches its capacity;
- the processor issues some other host command while characters are waiting.

In the third case the command is held back. It is passed on only after the host acknowledges the flush. While a flush is outstanding the block shows busy and drops character writes. A command issued when nothing is buffered goes straight through and causes no flush.

Top module: `char_coalesce_buf`

## Requirements
- R1: After reset, flush_req, busy, cmd_fwd and flush_count are all 0.
- R2: An accepted character is stored at the next free position, starting at position 0. While a flush is pending, rd_data shows the byte at position rd_addr.
- R3: Characters other than 0x0A never raise flush_req while the store holds fewer than DEPTH (128) bytes.
- R4: Writing 0x0A stores it and raises flush_req on the next cycle. flush_count includes the newline.
- R5: The write that fills the last free position raises flush_req with flush_count equal to DEPTH (128).
- R6: busy equals flush_req. Character writes while busy are dropped, and flush_count and the stored bytes stay unchanged.
- R7: host_ack while flush_req is high clears flush_req and flush_count on the next cycle. host_ack while no flush is pending has no effect.
- R8: cmd_req with a non-empty store raises flush_req and withholds cmd_fwd. cmd_fwd then pulses for exactly one cycle, in the cycle after the acknowledging edge.
- R9: cmd_req with an empty store pulses cmd_fwd for one cycle on the next cycle and raises no flush.
- R10: If a character write and cmd_req arrive in the same cycle, the character is stored first. The result is a flush whose count includes it, and the command is forwarded after the acknowledge.
- R11: cmd_req that arrives while a flush is outstanding is held. It is forwarded in the cycle after the acknowledging edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | Character write strobe |
| chr_data | input | 8 | Character to buffer |
| busy | output | 1 | Writes are dropped while high |
| cmd_req | input | 1 | Request to issue another host command |
| cmd_fwd | output | 1 | One-cycle pulse forwarding that command |
| flush_req | output | 1 | Flush-and-print request to host |
| flush_count | output | 8 | Number of buffered bytes |
| host_ack | input | 1 | Host has drained the buffer |
| rd_addr | input | 7 | Host read position |
| rd_data | output | 8 | Byte at rd_addr |

## Verification
The tests write plain text below capacity, which shows that no request appears early. They then send a newline-terminated line, which shows the newline trigger and that the newline is counted. A full run of 128 bytes separates the capacity trigger from the newline trigger. Commands are issued against an empty store, a filled store, a store with a write in the same cycle, and a store already flushing. This separates direct forwarding from held forwarding and checks the ordering between a write and a command. Writes and stray acknowledges applied while busy or idle are checked through flush_count and rd_data to show they change nothing.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam logic [7:0] NL_CODE = 8'h0A;

  function automatic logic is_newline(input logic [7:0] d);
    return d == NL_CODE;
  endfunction

  // true when one more write reaches capacity
  function automatic logic hits_cap(input int unsigned fill, input int unsigned cap);
    return (fill + 1) == cap;
  endfunction
endpackage

// File: rtl/ccb_store.sv
module ccb_store #(
  parameter int DEPTH = 128,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ccb_ctrl.sv
module ccb_ctrl
  import ccb_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [7:0]    chr_data,
  input  logic          cmd_req,
  input  logic          host_ack,
  output logic          wr_accept,
  output logic [CW-1:0] fill_cnt,
  output logic          flush_req,
  output logic          cmd_fwd,
  output logic          cmd_held,
  output logic          trig_nl,
  output logic          trig_full,
  output logic          trig_cmd
);
  logic [CW-1:0] next_cnt;

  assign wr_accept = chr_valid && !flush_req;
  assign next_cnt  = fill_cnt + CW'(wr_accept);
  assign trig_nl   = wr_accept && is_newline(chr_data);
  assign trig_full = wr_accept && hits_cap(int'(fill_cnt), DEPTH);
  assign trig_cmd  = !flush_req && cmd_req && (next_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      flush_req <= 1'b0;
      cmd_fwd   <= 1'b0;
      cmd_held  <= 1'b0;
    end else begin
      cmd_fwd <= 1'b0;
      if (flush_req) begin
        if (host_ack) begin
          flush_req <= 1'b0;
          fill_cnt  <= '0;
          cmd_fwd   <= cmd_held || cmd_req;
          cmd_held  <= 1'b0;
        end else if (cmd_req) begin
          cmd_held <= 1'b1;
        end
      end else begin
        fill_cnt <= next_cnt;
        if (trig_nl || trig_full) flush_req <= 1'b1;
        if (trig_cmd) begin
          flush_req <= 1'b1;
          cmd_held  <= 1'b1;
        end else if (cmd_req) begin
          cmd_fwd <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/char_coalesce_buf.sv
module char_coalesce_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [7:0]    chr_data,
  output logic          busy,
  input  logic          cmd_req,
  output logic          cmd_fwd,
  output logic          flush_req,
  output logic [CW-1:0] flush_count,
  input  logic          host_ack,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic          wr_accept, cmd_held, trig_nl, trig_full, trig_cmd;
  logic [CW-1:0] fill_cnt;

  ccb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .cmd_req(cmd_req), .host_ack(host_ack), .wr_accept(wr_accept),
    .fill_cnt(fill_cnt), .flush_req(flush_req), .cmd_fwd(cmd_fwd),
    .cmd_held(cmd_held), .trig_nl(trig_nl), .trig_full(trig_full),
    .trig_cmd(trig_cmd)
  );

  ccb_store #(.DEPTH(DEPTH), .DW(8)) store_i (
    .clk(clk), .we(wr_accept), .waddr(fill_cnt[AW-1:0]), .wdata(chr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign busy        = flush_req;
  assign flush_count = fill_cnt;
endmodule

// File: rtl/char_coalesce_buf_chk.sv
module char_coalesce_buf_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chr_valid,
  input logic          busy,
  input logic          cmd_req,
  input logic          cmd_fwd,
  input logic          flush_req,
  input logic [CW-1:0] flush_count,
  input logic          host_ack,
  input logic          wr_accept,
  input logic          cmd_held,
  input logic          trig_nl,
  input logic          trig_full
);
  // R6
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !host_ack) |=> $stable(flush_count));
  // R6
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_accept);
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && host_ack) |=> (!flush_req && flush_count == '0));
  // R9
  no_empty_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> flush_count != '0);
  // R4
  newline_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_nl |=> flush_req);
  // R5
  full_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_full |=> (flush_req && flush_count == CW'(DEPTH)));
  // R8
  held_cmd_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_held |-> flush_req);
  // R8
  fwd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fwd |=> !cmd_fwd);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_count <= CW'(DEPTH));
endmodule

bind char_coalesce_buf char_coalesce_buf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .busy(busy),
  .cmd_req(cmd_req), .cmd_fwd(cmd_fwd), .flush_req(flush_req),
  .flush_count(flush_count), .host_ack(host_ack), .wr_accept(wr_accept),
  .cmd_held(cmd_held), .trig_nl(trig_nl), .trig_full(trig_full)
);

// File: tb/char_coalesce_buf_tb_top.sv
module char_coalesce_buf_tb_top;
  localparam int DEPTH = 128;
  logic clk = 0, rst_n = 0;
  logic chr_valid = 0, cmd_req = 0, host_ack = 0;
  logic [7:0] chr_data = 0;
  logic [6:0] rd_addr = 0;
  logic busy, cmd_fwd, flush_req;
  logic [7:0] flush_count, rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  char_coalesce_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .busy(busy), .cmd_req(cmd_req), .cmd_fwd(cmd_fwd), .flush_req(flush_req),
    .flush_count(flush_count), .host_ack(host_ack), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive for one edge, then sample 1 ns after it
  task automatic step(input bit v, input logic [7:0] d, input bit c, input bit a);
    @(negedge clk);
    chr_valid = v; chr_data = d; cmd_req = c; host_ack = a;
    @(posedge clk); #1;
    chr_valid = 0; cmd_req = 0; host_ack = 0;
  endtask

  task automatic peek(input int addr, input int exp, input string req);
    rd_addr = 7'(addr); #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    check("R1 flush_req", int'(flush_req), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 cmd_fwd", int'(cmd_fwd), 0);
    check("R1 flush_count", int'(flush_count), 0);
  endtask

  task automatic t_newline;
    step(1, "h", 0, 0); step(1, "i", 0, 0);
    check("R3 no early flush", int'(flush_req), 0);
    step(1, 8'h0A, 0, 0);
    check("R4 flush raised", int'(flush_req), 1);
    check("R4 count incl newline", int'(flush_count), 3);
    check("R6 busy", int'(busy), 1);
    peek(0, "h", "R2 pos0"); peek(1, "i", "R2 pos1"); peek(2, 8'h0A, "R4 newline stored");
    step(1, "z", 0, 0);
    check("R6 count unchanged", int'(flush_count), 3);
    peek(0, "h", "R6 data unchanged");
    step(0, 0, 0, 1);
    check("R7 cleared", int'(flush_req), 0);
    check("R7 count zero", int'(flush_count), 0);
    check("R7 no fwd", int'(cmd_fwd), 0);
    step(0, 0, 0, 1);
    check("R7 stray ack", int'(flush_count), 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 8'(8'h41 + i % 26), 0, 0);
      if (i == DEPTH - 2) check("R3 below cap", int'(flush_req), 0);
    end
    check("R5 flush at full", int'(flush_req), 1);
    check("R5 count", int'(flush_count), DEPTH);
    peek(0, 8'h41, "R2 first");
    peek(DEPTH - 1, 8'(8'h41 + (DEPTH - 1) % 26), "R2 last");
    step(0, 0, 0, 1);
    check("R7 after full", int'(flush_count), 0);
  endtask

  task automatic t_cmd_empty;
    step(0, 0, 1, 0);
    check("R9 fwd pulse", int'(cmd_fwd), 1);
    check("R9 no flush", int'(flush_req), 0);
    step(0, 0, 0, 0);
    check("R9 pulse ends", int'(cmd_fwd), 0);
  endtask

  task automatic t_cmd_pending;
    step(1, "a", 0, 0);
    step(0, 0, 1, 0);
    check("R8 flush raised", int'(flush_req), 1);
    check("R8 count", int'(flush_count), 1);
    check("R8 withheld", int'(cmd_fwd), 0);
    step(0, 0, 0, 0);
    check("R8 still withheld", int'(cmd_fwd), 0);
    step(0, 0, 0, 1);
    check("R8 fwd after ack", int'(cmd_fwd), 1);
    step(0, 0, 0, 0);
    check("R8 single pulse", int'(cmd_fwd), 0);
  endtask

  task automatic t_same_cycle;
    step(1, "q", 1, 0);
    check("R10 flush", int'(flush_req), 1);
    check("R10 count", int'(flush_count), 1);
    check("R10 withheld", int'(cmd_fwd), 0);
    peek(0, "q", "R10 stored");
    step(0, 0, 0, 1);
    check("R10 fwd", int'(cmd_fwd), 1);
  endtask

  task automatic t_cmd_while_busy;
    step(1, 8'h0A, 0, 0);
    step(0, 0, 1, 0);
    check("R11 withheld", int'(cmd_fwd), 0);
    step(0, 0, 0, 1);
    check("R11 fwd after ack", int'(cmd_fwd), 1);
    check("R11 cleared", int'(flush_req), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_newline();
    t_full();
    t_cmd_empty();
    t_cmd_pending();
    t_same_cycle();
    t_cmd_while_busy();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule